// File: doc/BRIEF.md
# Power Mode State Controller

This block is the mode sequencer for a processor platform's power network. It keeps one registered mode out of eight: off, standby, full active, MCU-only, SoC power error, DDR retention, GPIO retention and safe recovery. From that mode it drives three rail-enable vectors, one for the MCU safety-island domains, one for the main processor domains and one for the retention rails. It also drives a driver-enable output and a flag that shows the controller has left its normal modes for safe recovery.

Transition requests arrive as single-cycle trigger pulses. In any one cycle they are resolved in a fixed priority order. The choice of retention flavour comes from two select bits that must be set up before the retention trigger. The driver-enable bit is written by the host. It is accepted only in the two modes where the host owns it. The controller clears it or forces it low in every other mode except SoC power error, where it holds its value.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the mode is off (code 0), every rail enable is 0, `drv_en` is 0 and `safe_rec_exit` is 0. From off, the first clock edge with `supply_ok` high moves the mode to standby (code 1).
- R2: When `supply_ok` is low at a clock edge and no error is being taken, the mode becomes off (code 0) with all outputs low, whatever other triggers are present.
- R3: In standby all rail enables and `drv_en` are 0. A `startup_evt` pulse moves the mode to active (code 2).
- R4: In active every MCU, main and retention rail enable is 1. A host write (`drv_wr`) loads `drv_wr_val` into `drv_en` on the next edge. `trig_mcu` moves the mode to MCU-only and `trig_socerr` moves it to SoC power error.
- R5: In MCU-only (code 3) only the MCU rail enables are 1. A host write loads `drv_en`, otherwise `drv_en` holds. `trig_active` returns the mode to active.
- R6: In SoC power error (code 4) only the MCU rail enables are 1 and `drv_en` holds its value while host writes are ignored. Only `trig_wake_b` leaves it, and it leads to MCU-only. Retention, active and MCU requests have no effect.
- R7: A `trig_ret` pulse in active or MCU-only enters DDR retention (code 5) when `ret_sel_ddr` is 1. It enters GPIO retention (code 6) when only `ret_sel_gpio` is 1. DDR wins when both are 1. With neither set the trigger is ignored.
- R8: In DDR retention the retention rails follow the mask `DDR_RET_MASK`, and in GPIO retention they follow `GPIO_RET_MASK`. MCU and main rails are 0 in both, and `drv_en` is cleared on entry and stays 0. `trig_active` wakes the block to active, and otherwise `trig_mcu` wakes it to MCU-only.
- R9: `err_flag` in any mode other than off or safe recovery moves the mode to safe recovery (code 7). There all rails and `drv_en` are 0 and `safe_rec_exit` is 1. `recover_done` returns the mode to standby.
- R10: Triggers arriving in the same cycle resolve as error first, then supply loss, then retention, then SoC error, then the active or MCU-only request.
- R11: Each mode change appears on `mode` one clock edge after its trigger, using the 3-bit codes given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | System supply above its undervoltage threshold |
| startup_evt | input | 1 | Start-up event pulse |
| trig_active | input | 1 | Request for full active mode |
| trig_mcu | input | 1 | Request for MCU-only mode |
| trig_socerr | input | 1 | SoC power error trigger |
| trig_wake_b | input | 1 | Return trigger out of SoC power error |
| trig_ret | input | 1 | Retention entry trigger |
| ret_sel_ddr | input | 1 | Preset select for DDR retention |
| ret_sel_gpio | input | 1 | Preset select for GPIO retention |
| err_flag | input | 1 | Error that forces safe recovery |
| recover_done | input | 1 | Safe recovery finished |
| drv_wr | input | 1 | Host write strobe for driver enable |
| drv_wr_val | input | 1 | Host write value for driver enable |
| mode | output | 3 | Current mode code |
| mcu_rail_en | output | N_MCU | MCU safety-island rail enables |
| main_rail_en | output | N_MAIN | Main processor rail enables |
| ret_rail_en | output | N_RET | Retention rail enables |
| drv_en | output | 1 | Driver-enable output |
| safe_rec_exit | output | 1 | Controller is in safe recovery |

## Verification
The bench builds the block with two MCU rails, three main rails and four retention rails. The DDR and GPIO masks are 4'b0101 and 4'b1001, and they overlap in bit 0. Because they overlap, a swapped or merged retention decode shows up in a single compare. Because the main and MCU vectors have different widths, a crossed vector also shows up. The small widths let every retention mask bit and every rail group be checked in each mode, both on the directed paths and on the pseudo-random trigger storm.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_OFF    = 3'd0,
    PM_STBY   = 3'd1,
    PM_ACT    = 3'd2,
    PM_MCU    = 3'd3,
    PM_SOCERR = 3'd4,
    PM_RDDR   = 3'd5,
    PM_RGPIO  = 3'd6,
    PM_RECOV  = 3'd7
  } pm_mode_e;

  // error can pull the controller out of this mode
  function automatic logic err_can_take(pm_mode_e m);
    return !(m inside {PM_OFF, PM_RECOV});
  endfunction

  // retention may be entered from this mode
  function automatic logic ret_capable(pm_mode_e m);
    return m inside {PM_ACT, PM_MCU};
  endfunction

  // host owns the driver-enable bit in this mode
  function automatic logic host_owns_drv(pm_mode_e m);
    return m inside {PM_ACT, PM_MCU};
  endfunction

  // driver enable is forced or cleared low in this mode
  function automatic logic drv_forced_low(pm_mode_e m);
    return m inside {PM_OFF, PM_STBY, PM_RDDR, PM_RGPIO, PM_RECOV};
  endfunction

  // retention flavour: DDR select wins over GPIO select
  function automatic pm_mode_e ret_target(logic sel_ddr);
    return sel_ddr ? PM_RDDR : PM_RGPIO;
  endfunction

  function automatic logic mcu_on(pm_mode_e m);
    return m inside {PM_ACT, PM_MCU, PM_SOCERR};
  endfunction

endpackage

// File: rtl/pmc_next.sv
module pmc_next
  import pmc_pkg::*;
(
  input  pm_mode_e mode_q,
  input  logic     supply_ok,
  input  logic     startup_evt,
  input  logic     trig_active,
  input  logic     trig_mcu,
  input  logic     trig_socerr,
  input  logic     trig_wake_b,
  input  logic     trig_ret,
  input  logic     ret_sel_ddr,
  input  logic     ret_sel_gpio,
  input  logic     err_flag,
  input  logic     recover_done,
  output pm_mode_e mode_d,
  output logic     evt_err,
  output logic     evt_uv,
  output logic     evt_ret,
  output logic     evt_ret_nosel
);

  logic ret_any_sel;

  assign ret_any_sel   = ret_sel_ddr | ret_sel_gpio;
  assign evt_err       = err_flag && err_can_take(mode_q);
  assign evt_uv        = !supply_ok && !evt_err;
  assign evt_ret       = !evt_err && !evt_uv && trig_ret && ret_capable(mode_q) && ret_any_sel;
  assign evt_ret_nosel = !evt_err && !evt_uv && trig_ret && ret_capable(mode_q) && !ret_any_sel;

  always_comb begin
    mode_d = mode_q;
    if (evt_err) begin
      mode_d = PM_RECOV;
    end else if (evt_uv) begin
      mode_d = PM_OFF;
    end else if (evt_ret) begin
      mode_d = ret_target(ret_sel_ddr);
    end else begin
      unique case (mode_q)
        PM_OFF:    mode_d = PM_STBY;
        PM_STBY:   if (startup_evt) mode_d = PM_ACT;
        PM_ACT: begin
          if (trig_socerr)   mode_d = PM_SOCERR;
          else if (trig_mcu) mode_d = PM_MCU;
        end
        PM_MCU:    if (trig_active) mode_d = PM_ACT;
        PM_SOCERR: if (trig_wake_b) mode_d = PM_MCU;
        PM_RDDR, PM_RGPIO: begin
          if (trig_active)   mode_d = PM_ACT;
          else if (trig_mcu) mode_d = PM_MCU;
        end
        PM_RECOV:  if (recover_done) mode_d = PM_STBY;
        default:   mode_d = PM_OFF;
      endcase
    end
  end

endmodule

// File: rtl/pmc_drv.sv
module pmc_drv
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pm_mode_e mode_q,
  input  pm_mode_e mode_d,
  input  logic     drv_wr,
  input  logic     drv_wr_val,
  output logic     drv_q
);

  logic drv_d;

  always_comb begin
    drv_d = drv_q;
    if (drv_forced_low(mode_d))
      drv_d = 1'b0;
    else if (drv_wr && host_owns_drv(mode_q))
      drv_d = drv_wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= drv_d;
  end

endmodule

// File: rtl/pmc_rails.sv
module pmc_rails
  import pmc_pkg::*;
#(
  parameter int unsigned        N_MCU         = 3,
  parameter int unsigned        N_MAIN        = 4,
  parameter int unsigned        N_RET         = 4,
  parameter logic [N_RET-1:0]   DDR_RET_MASK  = '1,
  parameter logic [N_RET-1:0]   GPIO_RET_MASK = '1
) (
  input  pm_mode_e          mode_q,
  output logic [N_MCU-1:0]  mcu_rail_en,
  output logic [N_MAIN-1:0] main_rail_en,
  output logic [N_RET-1:0]  ret_rail_en
);

  logic in_act, in_rddr, in_rgpio;

  assign in_act   = (mode_q == PM_ACT);
  assign in_rddr  = (mode_q == PM_RDDR);
  assign in_rgpio = (mode_q == PM_RGPIO);

  assign mcu_rail_en  = {N_MCU{mcu_on(mode_q)}};
  assign main_rail_en = {N_MAIN{in_act}};

  for (genvar gi = 0; gi < N_RET; gi++) begin : g_ret
    assign ret_rail_en[gi] = in_act
                           | (in_rddr  & DDR_RET_MASK[gi])
                           | (in_rgpio & GPIO_RET_MASK[gi]);
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned      N_MCU         = 3,
  parameter int unsigned      N_MAIN        = 4,
  parameter int unsigned      N_RET         = 4,
  parameter logic [N_RET-1:0] DDR_RET_MASK  = 4'b0011,
  parameter logic [N_RET-1:0] GPIO_RET_MASK = 4'b1100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              startup_evt,
  input  logic              trig_active,
  input  logic              trig_mcu,
  input  logic              trig_socerr,
  input  logic              trig_wake_b,
  input  logic              trig_ret,
  input  logic              ret_sel_ddr,
  input  logic              ret_sel_gpio,
  input  logic              err_flag,
  input  logic              recover_done,
  input  logic              drv_wr,
  input  logic              drv_wr_val,
  output logic [2:0]        mode,
  output logic [N_MCU-1:0]  mcu_rail_en,
  output logic [N_MAIN-1:0] main_rail_en,
  output logic [N_RET-1:0]  ret_rail_en,
  output logic              drv_en,
  output logic              safe_rec_exit
);

  pm_mode_e mode_q, mode_d;
  logic     evt_err, evt_uv, evt_ret, evt_ret_nosel;

  pmc_next u_next (
    .mode_q        (mode_q),
    .supply_ok     (supply_ok),
    .startup_evt   (startup_evt),
    .trig_active   (trig_active),
    .trig_mcu      (trig_mcu),
    .trig_socerr   (trig_socerr),
    .trig_wake_b   (trig_wake_b),
    .trig_ret      (trig_ret),
    .ret_sel_ddr   (ret_sel_ddr),
    .ret_sel_gpio  (ret_sel_gpio),
    .err_flag      (err_flag),
    .recover_done  (recover_done),
    .mode_d        (mode_d),
    .evt_err       (evt_err),
    .evt_uv        (evt_uv),
    .evt_ret       (evt_ret),
    .evt_ret_nosel (evt_ret_nosel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_OFF;
    else        mode_q <= mode_d;
  end

  pmc_drv u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .drv_wr     (drv_wr),
    .drv_wr_val (drv_wr_val),
    .drv_q      (drv_en)
  );

  pmc_rails #(
    .N_MCU         (N_MCU),
    .N_MAIN        (N_MAIN),
    .N_RET         (N_RET),
    .DDR_RET_MASK  (DDR_RET_MASK),
    .GPIO_RET_MASK (GPIO_RET_MASK)
  ) u_rails (
    .mode_q       (mode_q),
    .mcu_rail_en  (mcu_rail_en),
    .main_rail_en (main_rail_en),
    .ret_rail_en  (ret_rail_en)
  );

  assign mode          = mode_q;
  assign safe_rec_exit = (mode_q == PM_RECOV);

endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int unsigned      N_MCU         = 3,
  parameter int unsigned      N_MAIN        = 4,
  parameter int unsigned      N_RET         = 4,
  parameter logic [N_RET-1:0] DDR_RET_MASK  = 4'b0011,
  parameter logic [N_RET-1:0] GPIO_RET_MASK = 4'b1100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              trig_active,
  input logic              trig_mcu,
  input logic              ret_sel_ddr,
  input logic              drv_wr,
  input logic [2:0]        mode,
  input logic [N_MCU-1:0]  mcu_rail_en,
  input logic [N_MAIN-1:0] main_rail_en,
  input logic [N_RET-1:0]  ret_rail_en,
  input logic              drv_en,
  input logic              safe_rec_exit,
  input logic              evt_err,
  input logic              evt_ret
);

  // R2: supply loss without an error lands in off with everything dark
  a_r2_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !evt_err) |=> (mode == 3'd0 && mcu_rail_en == '0 &&
      main_rail_en == '0 && ret_rail_en == '0 && !drv_en && !safe_rec_exit));

  // R3: standby is fully dark
  a_r3_stby_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> (mcu_rail_en == '0 && main_rail_en == '0 &&
      ret_rail_en == '0 && !drv_en));

  // R5: MCU-only keeps main and retention rails off
  a_r5_mcu_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (mcu_rail_en == '1 && main_rail_en == '0 && ret_rail_en == '0));

  // R6: SoC error exits only to MCU-only, or through error or supply loss
  a_r6_socerr_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |=> (mode inside {3'd4, 3'd3, 3'd0, 3'd7}));

  // R6: host writes do not move driver enable in SoC error
  a_r6_drv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !evt_err && supply_ok && drv_wr) |=> $stable(drv_en));

  // R7: DDR select wins
  a_r7_ddr_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ret && ret_sel_ddr) |=> (mode == 3'd5 && ret_rail_en == DDR_RET_MASK));

  // R7: GPIO retention only when DDR is not selected
  a_r7_gpio_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ret && !ret_sel_ddr) |=> (mode == 3'd6 && ret_rail_en == GPIO_RET_MASK));

  // R8: driver enable is low throughout retention
  a_r8_ret_drv_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5 || mode == 3'd6) |-> (!drv_en && main_rail_en == '0 && mcu_rail_en == '0));

  // R8: retention wake goes to active when requested
  a_r8_wake_act: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd5 || mode == 3'd6) && trig_active && supply_ok && !evt_err) |=> (mode == 3'd2));

  // R9: error goes to safe recovery with rails and driver off
  a_r9_err_recov: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> (mode == 3'd7 && safe_rec_exit && !drv_en &&
      mcu_rail_en == '0 && main_rail_en == '0 && ret_rail_en == '0));

  // R10: supply loss overrides any request except an error
  a_r10_uv_over_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !evt_err && (trig_active || trig_mcu)) |=> (mode == 3'd0));

endmodule

bind pwr_mode_ctrl pmc_chk #(
  .N_MCU         (N_MCU),
  .N_MAIN        (N_MAIN),
  .N_RET         (N_RET),
  .DDR_RET_MASK  (DDR_RET_MASK),
  .GPIO_RET_MASK (GPIO_RET_MASK)
) u_pmc_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_ok     (supply_ok),
  .trig_active   (trig_active),
  .trig_mcu      (trig_mcu),
  .ret_sel_ddr   (ret_sel_ddr),
  .drv_wr        (drv_wr),
  .mode          (mode),
  .mcu_rail_en   (mcu_rail_en),
  .main_rail_en  (main_rail_en),
  .ret_rail_en   (ret_rail_en),
  .drv_en        (drv_en),
  .safe_rec_exit (safe_rec_exit),
  .evt_err       (evt_err),
  .evt_ret       (evt_ret)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;

  localparam int NM = 2;
  localparam int NX = 3;
  localparam int NR = 4;
  localparam logic [NR-1:0] DMASK = 4'b0101;
  localparam logic [NR-1:0] GMASK = 4'b1001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, startup_evt = 1'b0, trig_active = 1'b0, trig_mcu = 1'b0;
  logic trig_socerr = 1'b0, trig_wake_b = 1'b0, trig_ret = 1'b0;
  logic ret_sel_ddr = 1'b0, ret_sel_gpio = 1'b0, err_flag = 1'b0, recover_done = 1'b0;
  logic drv_wr = 1'b0, drv_wr_val = 1'b0;
  logic [2:0]    mode;
  logic [NM-1:0] mcu_rail_en;
  logic [NX-1:0] main_rail_en;
  logic [NR-1:0] ret_rail_en;
  logic drv_en, safe_rec_exit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  int ref_mode = 0;
  int ref_drv = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(
    .N_MCU(NM), .N_MAIN(NX), .N_RET(NR),
    .DDR_RET_MASK(DMASK), .GPIO_RET_MASK(GMASK)
  ) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .startup_evt(startup_evt),
    .trig_active(trig_active), .trig_mcu(trig_mcu), .trig_socerr(trig_socerr),
    .trig_wake_b(trig_wake_b), .trig_ret(trig_ret), .ret_sel_ddr(ret_sel_ddr),
    .ret_sel_gpio(ret_sel_gpio), .err_flag(err_flag), .recover_done(recover_done),
    .drv_wr(drv_wr), .drv_wr_val(drv_wr_val), .mode(mode), .mcu_rail_en(mcu_rail_en),
    .main_rail_en(main_rail_en), .ret_rail_en(ret_rail_en), .drv_en(drv_en),
    .safe_rec_exit(safe_rec_exit)
  );

  // reference model: one update per edge from the inputs set at the previous falling edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_mode = 0;
      ref_drv  = 0;
    end else begin
      int nx;
      bool_blk: begin
        nx = ref_mode;
        if (err_flag && ref_mode != 0 && ref_mode != 7) nx = 7;
        else if (!supply_ok) nx = 0;
        else if (trig_ret && (ref_mode == 2 || ref_mode == 3) && (ret_sel_ddr || ret_sel_gpio))
          nx = ret_sel_ddr ? 5 : 6;
        else if (ref_mode == 0) nx = 1;
        else if (ref_mode == 1 && startup_evt) nx = 2;
        else if (ref_mode == 2 && trig_socerr) nx = 4;
        else if (ref_mode == 2 && trig_mcu) nx = 3;
        else if (ref_mode == 3 && trig_active) nx = 2;
        else if (ref_mode == 4 && trig_wake_b) nx = 3;
        else if ((ref_mode == 5 || ref_mode == 6) && trig_active) nx = 2;
        else if ((ref_mode == 5 || ref_mode == 6) && trig_mcu) nx = 3;
        else if (ref_mode == 7 && recover_done) nx = 1;
      end
      if (nx == 0 || nx == 1 || nx >= 5) ref_drv = 0;
      else if (drv_wr && (ref_mode == 2 || ref_mode == 3)) ref_drv = drv_wr_val ? 1 : 0;
      ref_mode = nx;
    end
  end

  function automatic string tag_of(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5, 6: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int pack_exp(int m, int d);
    int mc, mn, rt;
    mc = (m >= 2 && m <= 4) ? ((1 << NM) - 1) : 0;
    mn = (m == 2) ? ((1 << NX) - 1) : 0;
    rt = (m == 2) ? ((1 << NR) - 1) : (m == 5) ? int'(DMASK) : (m == 6) ? int'(GMASK) : 0;
    return (m << 13) | (mc << 11) | (mn << 8) | (rt << 4) | (d << 1) | (m == 7 ? 1 : 0);
  endfunction

  function automatic int pack_act();
    return (int'(mode) << 13) | (int'(mcu_rail_en) << 11) | (int'(main_rail_en) << 8) |
           (int'(ret_rail_en) << 4) | (int'(drv_en) << 1) | int'(safe_rec_exit);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clr();
    startup_evt = 0; trig_active = 0; trig_mcu = 0; trig_socerr = 0; trig_wake_b = 0;
    trig_ret = 0; err_flag = 0; recover_done = 0; drv_wr = 0;
  endtask

  // advance one edge and compare the whole output image against the model
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(tag_of(ref_mode), pack_act(), pack_exp(ref_mode, ref_drv));
    clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    supply_ok = 1;
    repeat (3) @(negedge clk);
    // R1: reset image
    chk("R1", pack_act(), 0);
    rst_n = 1;
    step();
    chk("R1", int'(mode), 1);
    chk("R3", int'(drv_en), 0);
    startup_evt = 1; step();
    chk("R11", int'(mode), 2);
    chk("R4", int'(main_rail_en), 7);
    drv_wr = 1; drv_wr_val = 1; step();
    chk("R4", int'(drv_en), 1);
    // R7: no select -> ignored
    trig_ret = 1; step();
    chk("R7", int'(mode), 2);
    // R7 / R10: both selects, with a lower-priority MCU request -> DDR retention
    ret_sel_ddr = 1; ret_sel_gpio = 1; trig_ret = 1; trig_mcu = 1; step();
    chk("R7", int'(mode), 5);
    chk("R8", int'(ret_rail_en), int'(DMASK));
    chk("R8", int'(drv_en), 0);
    trig_active = 1; trig_mcu = 1; step();
    chk("R8", int'(mode), 2);
    ret_sel_ddr = 0; trig_ret = 1; step();
    chk("R7", int'(mode), 6);
    chk("R8", int'(ret_rail_en), int'(GMASK));
    trig_mcu = 1; step();
    chk("R8", int'(mode), 3);
    drv_wr = 1; drv_wr_val = 1; step();
    chk("R5", int'(drv_en), 1);
    trig_active = 1; step();
    trig_socerr = 1; step();
    chk("R6", int'(mode), 4);
    trig_active = 1; trig_ret = 1; trig_mcu = 1; drv_wr = 1; drv_wr_val = 0; step();
    chk("R6", int'(mode), 4);
    chk("R6", int'(drv_en), 1);
    trig_wake_b = 1; step();
    chk("R6", int'(mode), 3);
    // R10: error beats supply loss
    err_flag = 1; supply_ok = 0; step();
    chk("R10", int'(mode), 7);
    chk("R9", int'(safe_rec_exit), 1);
    step();
    chk("R2", int'(mode), 0);
    supply_ok = 1; step();
    chk("R2", int'(mode), 1);
    startup_evt = 1; step();
    // R10: supply loss beats retention
    trig_ret = 1; supply_ok = 0; step();
    chk("R10", int'(mode), 0);
    supply_ok = 1; step();
    startup_evt = 1; step();
    err_flag = 1; step();
    chk("R9", int'(mode), 7);
    recover_done = 1; step();
    chk("R9", int'(mode), 1);

    // pseudo-random trigger storm checked every cycle against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      supply_ok    = (lfsr[5:0] != 0);
      err_flag     = (lfsr[11:6] == 6'h2a);
      startup_evt  = lfsr[0];
      trig_active  = lfsr[1] & lfsr[2];
      trig_mcu     = lfsr[3] & lfsr[4];
      trig_socerr  = lfsr[5] & lfsr[7] & lfsr[8];
      trig_wake_b  = lfsr[9] & lfsr[10];
      trig_ret     = lfsr[11] & lfsr[12];
      recover_done = lfsr[13];
      drv_wr       = lfsr[14];
      drv_wr_val   = lfsr[15];
      if (lfsr[7:4] == 4'h3) begin
        ret_sel_ddr  = lfsr[8];
        ret_sel_gpio = lfsr[9];
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag_of(ref_mode), pack_act(), pack_exp(ref_mode, ref_drv));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule